// File: doc/BRIEF.md
# Sticky Right Shifter with Extra Fraction Word

This block aligns a significand held as a two-word fixed-point number: an upper word holding the integer part and a lower word holding the fraction, with the binary point between them. It shifts the value right by an unsigned count and returns a new integer word and a new fraction word. The most recent bit pushed out of the integer word lands in the fraction MSB. Everything further down collapses into the fraction LSB as a sticky flag, so a later rounding stage can tell exactly-half from above-half.

The count may be any value its input can carry. Counts at or beyond one word flush the integer word, and counts beyond one word keep only a single nonzero flag. A parameter selects a purely combinational datapath or one output register stage with a valid bit travelling alongside the data. Rounding, exponent arithmetic and normalization belong to the surrounding unit.

Top module: `sticky_extra_shifter`

## Requirements
- R1: A count of 0 returns the integer word and the fraction word unchanged.
- R2: For counts 1 to W-1 (W = 64), the output integer word equals the input integer word shifted right by the count, with zeros filled in at the top.
- R3: For counts 1 to W-1, the top `count` bits of the output fraction are the low `count` bits of the input integer word, in order. The bits below them are zero, except bit 0, which is also set when the input fraction word is nonzero.
- R4: For a count of exactly W, the output integer word is zero. The output fraction is the input integer word with bit 0 ORed with "input fraction nonzero".
- R5: For counts above W, the output integer word is zero. The output fraction is 1 when either input word is nonzero and 0 otherwise.
- R6: The count is an unsigned 8-bit value and is never taken modulo the word width. Counts 128 and 255 follow R5, not R1 or R2/R3.
- R7: With `REG_OUT` = 1, results and `out_valid` appear one clock after the inputs and `in_valid` that produced them. With `REG_OUT` = 0, they follow the inputs in the same cycle.
- R8: While `rst_n` is low, the registered build drives `out_valid`, `out_int` and `out_frac` to zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the input operands |
| in_int | input | 64 | Integer word of the input (above the binary point) |
| in_frac | input | 64 | Fraction word of the input (below the binary point) |
| shift_amt | input | 8 | Unsigned right-shift count |
| out_valid | output | 1 | Qualifies the result |
| out_int | output | 64 | Integer word of the shifted result |
| out_frac | output | 64 | Fraction word: last bit out on top, sticky flag in bit 0 |

## Verification
Counts 0, 1, 7, 32, 63, 64, 65, 127, 128 and 255 are each applied to several operands. The operands are: all ones, all zero, integer word only, fraction word only, a lone integer LSB, a lone integer MSB, and an alternating pattern. The lone LSB at count 1 and the lone MSB at count 64 show that the last bit shifted out reaches the fraction MSB. The fraction-only operand separates the sticky bit from the shifted data at every count. The all-zero operand at counts above 64 confirms the flush flag stays clear. Counts 128 and 255 would expose any wrap of the count back into the pass-through or partial ranges. Idle gaps between operands check that the valid bit follows its data cycle for cycle. A combinational instance is compared in the same cycle it is driven.

// File: rtl/sxs_pkg.sv
package sxs_pkg;

    // Which of the four shift behaviours a count selects
    typedef enum logic [1:0] {
        RGN_PASS  = 2'd0,   // count == 0
        RGN_PART  = 2'd1,   // 0 < count < word width
        RGN_WHOLE = 2'd2,   // count == word width
        RGN_FLUSH = 2'd3    // count > word width
    } shift_region_e;

endpackage

// File: rtl/sxs_count_decode.sv
module sxs_count_decode
    import sxs_pkg::*;
#(
    parameter int W  = 64,
    parameter int CW = 8
) (
    input  logic [CW-1:0]         cnt,
    output shift_region_e         region,
    output logic [$clog2(W)-1:0]  sub_amt
);
    localparam int SW = $clog2(W);
    localparam logic [CW-1:0] WORD_CNT = CW'(W);

    always_comb begin
        sub_amt = cnt[SW-1:0];
        if (cnt == '0) begin
            region = RGN_PASS;
        end else if (cnt < WORD_CNT) begin
            region = RGN_PART;
        end else if (cnt == WORD_CNT) begin
            region = RGN_WHOLE;
        end else begin
            region = RGN_FLUSH;
        end
    end
endmodule

// File: rtl/sxs_funnel.sv
module sxs_funnel #(
    parameter int W = 64
) (
    input  logic [W-1:0]          word_in,
    input  logic [$clog2(W)-1:0]  amt,
    output logic [W-1:0]          kept,
    output logic [W-1:0]          spill
);
    localparam int SW = $clog2(W);

    // Logarithmic stages over a double-width vector: the upper half keeps
    // the shifted word, the lower half collects what fell off, MSB first.
    logic [2*W-1:0] stage [SW+1];

    assign stage[0] = {word_in, {W{1'b0}}};

    for (genvar k = 0; k < SW; k++) begin : g_stage
        always_comb begin
            if (amt[k]) begin
                stage[k+1] = stage[k] >> (1 << k);
            end else begin
                stage[k+1] = stage[k];
            end
        end
    end

    assign kept  = stage[SW][2*W-1:W];
    assign spill = stage[SW][W-1:0];
endmodule

// File: rtl/sxs_nonzero.sv
module sxs_nonzero #(
    parameter int W = 64
) (
    input  logic [W-1:0] hi_word,
    input  logic [W-1:0] lo_word,
    output logic         lo_nz,
    output logic         any_nz
);
    localparam int HALF = W / 2;

    // Each word reduced in two halves, then merged
    logic lo_a, lo_b, hi_a, hi_b;

    always_comb begin
        lo_a   = |lo_word[HALF-1:0];
        lo_b   = |lo_word[W-1:HALF];
        hi_a   = |hi_word[HALF-1:0];
        hi_b   = |hi_word[W-1:HALF];
        lo_nz  = lo_a | lo_b;
        any_nz = lo_nz | hi_a | hi_b;
    end
endmodule

// File: rtl/sticky_extra_shifter.sv
module sticky_extra_shifter
    import sxs_pkg::*;
#(
    parameter int W       = 64,
    parameter int CW      = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_int,
    input  logic [W-1:0]  in_frac,
    input  logic [CW-1:0] shift_amt,
    output logic          out_valid,
    output logic [W-1:0]  out_int,
    output logic [W-1:0]  out_frac
);
    localparam int SW = $clog2(W);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] ipart;
        logic [W-1:0] fpart;
    } result_t;

    shift_region_e   region;
    logic [SW-1:0]   sub_amt;
    logic [W-1:0]    kept;
    logic [W-1:0]    spill;
    logic            lo_nz;
    logic            any_nz;
    result_t         res_d;

    sxs_count_decode #(.W(W), .CW(CW)) u_decode (
        .cnt     (shift_amt),
        .region  (region),
        .sub_amt (sub_amt)
    );

    sxs_funnel #(.W(W)) u_funnel (
        .word_in (in_int),
        .amt     (sub_amt),
        .kept    (kept),
        .spill   (spill)
    );

    sxs_nonzero #(.W(W)) u_nonzero (
        .hi_word (in_int),
        .lo_word (in_frac),
        .lo_nz   (lo_nz),
        .any_nz  (any_nz)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = in_valid;
        unique case (region)
            RGN_PASS: begin
                res_d.ipart = in_int;
                res_d.fpart = in_frac;
            end
            RGN_PART: begin
                res_d.ipart = kept;
                res_d.fpart = spill | {{(W-1){1'b0}}, lo_nz};
            end
            RGN_WHOLE: begin
                res_d.ipart = '0;
                res_d.fpart = in_int | {{(W-1){1'b0}}, lo_nz};
            end
            default: begin
                res_d.ipart = '0;
                res_d.fpart = {{(W-1){1'b0}}, any_nz};
            end
        endcase
    end

    if (REG_OUT) begin : g_reg
        result_t res_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end
        assign out_valid = res_q.vld;
        assign out_int   = res_q.ipart;
        assign out_frac  = res_q.fpart;
    end else begin : g_comb
        assign out_valid = res_d.vld;
        assign out_int   = res_d.ipart;
        assign out_frac  = res_d.fpart;
    end
endmodule

// File: rtl/sxs_checker.sv
module sxs_checker #(
    parameter int W       = 64,
    parameter int CW      = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [W-1:0]  in_int,
    input logic [W-1:0]  in_frac,
    input logic [CW-1:0] shift_amt,
    input logic          out_valid,
    input logic [W-1:0]  out_int,
    input logic [W-1:0]  out_frac
);
    localparam logic [CW-1:0] WORD_CNT = CW'(W);

    // Inputs aligned to the cycle in which their result is visible
    logic          armed;
    logic          vld_p;
    logic [W-1:0]  hi_p;
    logic [W-1:0]  lo_p;
    logic [CW-1:0] cnt_p;

    if (REG_OUT) begin : g_delay
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                armed <= 1'b0;
                vld_p <= 1'b0;
                hi_p  <= '0;
                lo_p  <= '0;
                cnt_p <= '0;
            end else begin
                armed <= 1'b1;
                vld_p <= in_valid;
                hi_p  <= in_int;
                lo_p  <= in_frac;
                cnt_p <= shift_amt;
            end
        end
    end else begin : g_direct
        assign armed = rst_n;
        assign vld_p = in_valid;
        assign hi_p  = in_int;
        assign lo_p  = in_frac;
        assign cnt_p = shift_amt;
    end

    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cnt_p == '0 |-> out_int == hi_p && out_frac == lo_p);

    p_int_part_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cnt_p != '0 && cnt_p < WORD_CNT |-> out_int == (hi_p >> cnt_p));

    p_frac_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cnt_p != '0 && lo_p != '0 |-> out_frac[0]);

    p_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cnt_p == WORD_CNT |-> out_int == '0 && out_frac[W-1:1] == hi_p[W-1:1]);

    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cnt_p > WORD_CNT |->
        out_int == '0 && out_frac[W-1:1] == '0 && out_frac[0] == ((hi_p | lo_p) != '0));

    p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> out_valid == vld_p);
endmodule

bind sticky_extra_shifter sxs_checker #(.W(W), .CW(CW), .REG_OUT(REG_OUT)) u_sxs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_int    (in_int),
    .in_frac   (in_frac),
    .shift_amt (shift_amt),
    .out_valid (out_valid),
    .out_int   (out_int),
    .out_frac  (out_frac)
);

// File: tb/sticky_extra_shifter_tb.sv
module sticky_extra_shifter_tb_top;
    localparam int W     = 64;
    localparam int CW    = 8;
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_int = '0;
    logic [W-1:0]  in_frac = '0;
    logic [CW-1:0] shift_amt = '0;
    logic          out_valid;
    logic [W-1:0]  out_int;
    logic [W-1:0]  out_frac;
    logic          c_valid;
    logic [W-1:0]  c_int;
    logic [W-1:0]  c_frac;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [2*W-1:0] exp_q [$];
    string          tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    sticky_extra_shifter #(.W(W), .CW(CW), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
        .in_frac(in_frac), .shift_amt(shift_amt),
        .out_valid(out_valid), .out_int(out_int), .out_frac(out_frac)
    );

    sticky_extra_shifter #(.W(W), .CW(CW), .REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
        .in_frac(in_frac), .shift_amt(shift_amt),
        .out_valid(c_valid), .out_int(c_int), .out_frac(c_frac)
    );

    // Reference: wide shift of the integer word, then sticky folding
    function automatic logic [2*W-1:0] model(logic [W-1:0] hi, logic [W-1:0] lo, int c);
        logic [4*W-1:0] wide;
        logic [W-1:0]   ip;
        logic [W-1:0]   fp;
        if (c == 0) return {hi, lo};
        if (c > W) return {{W{1'b0}}, {(W-1){1'b0}}, ((hi | lo) != '0)};
        wide = {hi, {(3*W){1'b0}}} >> c;
        ip = wide[4*W-1:3*W];
        fp = wide[3*W-1:2*W];
        fp[0] = fp[0] | (lo != '0) | (wide[2*W-1:0] != '0);
        return {ip, fp};
    endfunction

    function automatic string req_tag(int c);
        if (c == 0) return "R1";
        if (c < W) return "R2 R3";
        if (c == W) return "R4";
        if (c >= 128) return "R5 R6";
        return "R5";
    endfunction

    task automatic check(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one operand, pushes its expectation, checks the
    // combinational build in the same cycle (R7)
    task automatic drive(logic [W-1:0] hi, logic [W-1:0] lo, int c);
        logic [2*W-1:0] e;
        @(posedge clk);
        #1;
        in_valid  = 1'b1;
        in_int    = hi;
        in_frac   = lo;
        shift_amt = CW'(c);
        e = model(hi, lo, c);
        exp_q.push_back(e);
        tag_q.push_back(req_tag(c));
        #(CLK_P/4);
        check({"R7 comb ", req_tag(c)}, {c_int, c_frac}, e);
        check("R7 comb valid", {{(2*W-1){1'b0}}, c_valid}, {{(2*W-1){1'b0}}, 1'b1});
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // Monitor: pops one expectation per valid result (R7 timing)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected valid", 1, 0);
            end else begin
                check({"reg ", tag_q.pop_front()}, {out_int, out_frac}, exp_q.pop_front());
            end
        end
    end

    initial begin
        int cycles = 0;
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                total++;
                bad++;
                $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int counts [10] = '{0, 1, 7, 32, 63, 64, 65, 127, 128, 255};
        logic [W-1:0] his [7];
        logic [W-1:0] los [7];
        his[0] = '1;               los[0] = '1;
        his[1] = '0;               los[1] = '0;
        his[2] = 64'hDEAD_BEEF_0123_4567; los[2] = '0;
        his[3] = '0;               los[3] = 64'h0000_0000_0000_0100;
        his[4] = 64'h1;            los[4] = '0;
        his[5] = 64'h8000_0000_0000_0000; los[5] = '0;
        his[6] = 64'hAAAA_5555_AAAA_5555; los[6] = 64'h0F0F_0000_0000_0001;

        // R8: reset dominates live inputs
        in_valid = 1'b1;
        in_int = '1;
        in_frac = '1;
        shift_amt = 8'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset outputs", {out_int, out_frac}, '0);
        check("R8 reset valid", {{(2*W-1){1'b0}}, out_valid}, '0);
        #1;
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Direct boundary checks against hand-worked values
        check("R3 model lsb c=1", model(64'h1, 64'h0, 1),
              {64'h0, 64'h8000_0000_0000_0000});
        check("R4 model msb c=64", model(64'h8000_0000_0000_0000, 64'h1, 64),
              {64'h0, 64'h8000_0000_0000_0001});

        for (int p = 0; p < 7; p++) begin
            for (int i = 0; i < 10; i++) begin
                drive(his[p], los[p], counts[i]);
                if (i == 4) idle();
            end
            idle();
            idle();
        end
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 queue drained", {{(2*W-32){1'b0}}, 32'(exp_q.size())}, '0);
        check("R7 valid low after stream", {{(2*W-1){1'b0}}, out_valid}, '0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule